// File: doc/BRIEF.md
# Rotating-Parity Small-Write Controller

This block takes one logical block write at a time for a five-column disk array whose parity column moves from stripe to stripe. It turns the logical block number into a stripe number, the data column that holds the block, and the column that holds that stripe's parity. It then runs a read-modify-write on the disk side and updates both the data block and the parity block.

Each accepted write becomes four physical operations on a single-outstanding command port, always in the same order:

1. Fetch the old data.
2. Fetch the old parity.
3. Store the new data.
4. Store the recomputed parity, which is new data XOR old data XOR old parity.

The host side sees a ready flag that is low while a write is in flight. It also sees a one-cycle completion pulse after the parity store has been accepted.

Top module: `r5_small_write_ctrl`

## Requirements
- R1: While reset is low and in the first cycle after it, busy=0, done=0, dk_valid=0 and req_ready=1.
- R2: The stripe number driven on dk_stripe for all four operations equals the logical block number divided by 4. The column index within the stripe is the remainder of that division.
- R3: The parity column is 4 minus (stripe mod 5). Stripe 0 keeps parity on disk 4 and stripe 4 on disk 0, and the pattern repeats every five stripes. Disks are numbered 0 to 4 on dk_disk.
- R4: The data disk equals the column index when the column index is below the parity disk, and the column index plus one otherwise. For example, block 7 maps to stripe 1, disk 4.
- R5: Each accepted write issues exactly four commands, in this order: read data disk (dk_write=0), read parity disk (dk_write=0), write data disk with the request data (dk_write=1), write parity disk (dk_write=1).
- R6: A command is presented with dk_valid and holds all of its fields until dk_ready. Nothing else is outstanding: a read command is followed by no new command until a read return (rd_valid) has been taken.
- R7: The data written to the parity disk equals the new data XOR the returned old data XOR the returned old parity.
- R8: An rd_valid pulse while no read is awaiting its return is ignored and does not alter the parity written.
- R9: A request is accepted when req_valid and req_ready are both high. busy is high from the cycle after acceptance up to and including the cycle in which the parity write is acknowledged, and req_ready is its inverse. A request presented while busy is refused and leaves no trace.
- R10: done is high for exactly one cycle: the cycle after the parity write handshake.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Host write request present |
| req_ready | output | 1 | Controller can take a request |
| req_lba | input | LBA_W | Logical block number of the write |
| req_data | input | BLK_W | New block contents |
| busy | output | 1 | Read-modify-write in progress |
| done | output | 1 | One-cycle completion pulse |
| dk_valid | output | 1 | Disk command present |
| dk_ready | input | 1 | Disk side accepts the command |
| dk_disk | output | clog2(NUM_DISKS) | Target disk column |
| dk_stripe | output | LBA_W | Target stripe |
| dk_write | output | 1 | 1 = write, 0 = read |
| dk_wdata | output | BLK_W | Write data |
| rd_valid | input | 1 | Read data return strobe |
| rd_data | input | BLK_W | Returned block contents |

## Verification
The ports expose a wrong sequencer state at the next command handshake: a missing, repeated or reordered operation appears as a mismatch in dk_write or dk_disk, or as a stray dk_valid, within one clock. A fault in the address mapping shows up on the very first command after acceptance, as a wrong disk or stripe. A corrupt parity accumulator, including one that folds in a spurious read strobe, stays hidden until the fourth command, where dk_wdata differs. Any lasting damage also breaks the XOR balance of the affected stripe in the bench's disk image. Faults in busy and done appear in the cycle they occur.

// File: rtl/r5_pkg.sv
// Package r5_pkg
// Shared types for the rotating-parity small-write controller.
// Assumes: nothing beyond IEEE 1800-2017.
package r5_pkg;

    // Sequencer steps of one read-modify-write
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_RD_OLD = 3'd1,
        ST_WT_OLD = 3'd2,
        ST_RD_PAR = 3'd3,
        ST_WT_PAR = 3'd4,
        ST_WR_DAT = 3'd5,
        ST_WR_PAR = 3'd6
    } seq_state_t;

endpackage

// File: rtl/r5_addr_map.sv
// Module r5_addr_map
// Purely combinational mapping of a logical block number to stripe,
// data disk and parity disk. Parity sits on the last disk for stripe 0
// and moves one disk left per stripe, wrapping every NUM_DISKS stripes.
// Assumes: NUM_DISKS >= 3.
module r5_addr_map #(
    parameter int NUM_DISKS = 5,
    parameter int LBA_W     = 16,
    localparam int DW       = $clog2(NUM_DISKS)
) (
    input  logic [LBA_W-1:0] lba,
    output logic [LBA_W-1:0] stripe,
    output logic [DW-1:0]    data_disk,
    output logic [DW-1:0]    par_disk
);

    localparam logic [LBA_W-1:0] DATA_COLS = LBA_W'(NUM_DISKS - 1);
    localparam logic [LBA_W-1:0] ALL_COLS  = LBA_W'(NUM_DISKS);

    logic [LBA_W-1:0] par_wide;
    logic [LBA_W-1:0] col_wide;

    // Stripe is the quotient over the data columns per stripe
    assign stripe = lba / DATA_COLS;

    // Column index within the stripe, before skipping the parity disk
    assign col_wide = lba % DATA_COLS;

    // Parity rotates right-to-left with the stripe number
    assign par_wide = DATA_COLS - (stripe % ALL_COLS);

    // Data columns at or beyond the parity disk shift one to the right
    always_comb begin
        if (col_wide < par_wide) begin
            data_disk = DW'(col_wide);
        end else begin
            data_disk = DW'(col_wide + LBA_W'(1));
        end
    end

    assign par_disk = DW'(par_wide);

endmodule

// File: rtl/r5_seq_fsm.sv
// Module r5_seq_fsm
// Four-step read-modify-write sequencer: read old data, read old parity,
// write new data, write new parity. One disk command outstanding at a
// time; read returns are only taken in the two wait states.
// Assumes: rd_valid for a read arrives no earlier than the cycle after
// that read's command handshake.
module r5_seq_fsm
    import r5_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic cmd_ready,
    input  logic rd_valid,
    output logic cmd_valid,
    output logic cmd_write,
    output logic cmd_par,
    output logic capture,
    output logic fold,
    output logic busy,
    output logic done
);

    seq_state_t state_q, state_d;
    logic       done_q;

    // Next-state selection for the sequencer
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid) state_d = ST_RD_OLD;
            ST_RD_OLD: if (cmd_ready) state_d = ST_WT_OLD;
            ST_WT_OLD: if (rd_valid)  state_d = ST_RD_PAR;
            ST_RD_PAR: if (cmd_ready) state_d = ST_WT_PAR;
            ST_WT_PAR: if (rd_valid)  state_d = ST_WR_DAT;
            ST_WR_DAT: if (cmd_ready) state_d = ST_WR_PAR;
            ST_WR_PAR: if (cmd_ready) state_d = ST_IDLE;
            default:                  state_d = ST_IDLE;
        endcase
    end

    // State and completion registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= (state_q == ST_WR_PAR) && cmd_ready;
        end
    end

    // Command-phase decode from the current state
    always_comb begin
        cmd_valid = 1'b0;
        cmd_write = 1'b0;
        cmd_par   = 1'b0;
        unique case (state_q)
            ST_RD_OLD: begin cmd_valid = 1'b1; end
            ST_RD_PAR: begin cmd_valid = 1'b1; cmd_par = 1'b1; end
            ST_WR_DAT: begin cmd_valid = 1'b1; cmd_write = 1'b1; end
            ST_WR_PAR: begin cmd_valid = 1'b1; cmd_write = 1'b1; cmd_par = 1'b1; end
            default:   begin cmd_valid = 1'b0; end
        endcase
    end

    assign busy    = (state_q != ST_IDLE);
    assign capture = (state_q == ST_IDLE) && req_valid;
    assign fold    = ((state_q == ST_WT_OLD) || (state_q == ST_WT_PAR)) && rd_valid;
    assign done    = done_q;

endmodule

// File: rtl/r5_parity_acc.sv
// Module r5_parity_acc
// Holds the new block and an XOR accumulator seeded with it; each read
// return folded in leaves new ^ old ^ parity after both reads.
// Assumes: capture and fold are never high together.
module r5_parity_acc #(
    parameter int BLK_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture,
    input  logic             fold,
    input  logic [BLK_W-1:0] new_in,
    input  logic [BLK_W-1:0] rd_in,
    output logic [BLK_W-1:0] new_blk,
    output logic [BLK_W-1:0] par_blk
);

    logic [BLK_W-1:0] new_q;
    logic [BLK_W-1:0] acc_q;

    // Latch new data and run the XOR accumulation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            new_q <= '0;
            acc_q <= '0;
        end else if (capture) begin
            new_q <= new_in;
            acc_q <= new_in;
        end else if (fold) begin
            acc_q <= acc_q ^ rd_in;
        end
    end

    assign new_blk = new_q;
    assign par_blk = acc_q;

endmodule

// File: rtl/r5_small_write_ctrl.sv
// Module r5_small_write_ctrl
// Top of the rotating-parity small-write controller. Maps the request,
// latches the mapping, sequences four disk operations and steers the
// command fields from the mapping and the parity accumulator.
// Assumes: one request in flight; the disk side returns each read once.
module r5_small_write_ctrl #(
    parameter int NUM_DISKS = 5,
    parameter int LBA_W     = 16,
    parameter int BLK_W     = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         req_valid,
    output logic                         req_ready,
    input  logic [LBA_W-1:0]             req_lba,
    input  logic [BLK_W-1:0]             req_data,
    output logic                         busy,
    output logic                         done,
    output logic                         dk_valid,
    input  logic                         dk_ready,
    output logic [$clog2(NUM_DISKS)-1:0] dk_disk,
    output logic [LBA_W-1:0]             dk_stripe,
    output logic                         dk_write,
    output logic [BLK_W-1:0]             dk_wdata,
    input  logic                         rd_valid,
    input  logic [BLK_W-1:0]             rd_data
);

    localparam int DW = $clog2(NUM_DISKS);

    logic [LBA_W-1:0] map_stripe;
    logic [DW-1:0]    map_ddisk;
    logic [DW-1:0]    map_pdisk;
    logic [LBA_W-1:0] stripe_q;
    logic [DW-1:0]    ddisk_q;
    logic [DW-1:0]    pdisk_q;
    logic             capture;
    logic             fold;
    logic             cmd_par;
    logic             seq_busy;
    logic [BLK_W-1:0] new_blk;
    logic [BLK_W-1:0] par_blk;

    r5_addr_map #(
        .NUM_DISKS (NUM_DISKS),
        .LBA_W     (LBA_W)
    ) map_i (
        .lba       (req_lba),
        .stripe    (map_stripe),
        .data_disk (map_ddisk),
        .par_disk  (map_pdisk)
    );

    r5_seq_fsm seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .cmd_ready (dk_ready),
        .rd_valid  (rd_valid),
        .cmd_valid (dk_valid),
        .cmd_write (dk_write),
        .cmd_par   (cmd_par),
        .capture   (capture),
        .fold      (fold),
        .busy      (seq_busy),
        .done      (done)
    );

    r5_parity_acc #(
        .BLK_W (BLK_W)
    ) acc_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (capture),
        .fold    (fold),
        .new_in  (req_data),
        .rd_in   (rd_data),
        .new_blk (new_blk),
        .par_blk (par_blk)
    );

    // Hold the mapping of the accepted request for all four operations
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stripe_q <= '0;
            ddisk_q  <= '0;
            pdisk_q  <= '0;
        end else if (capture) begin
            stripe_q <= map_stripe;
            ddisk_q  <= map_ddisk;
            pdisk_q  <= map_pdisk;
        end
    end

    // Steer disk and data by whether the step targets parity
    always_comb begin
        dk_disk  = cmd_par ? pdisk_q : ddisk_q;
        dk_wdata = cmd_par ? par_blk : new_blk;
    end

    assign dk_stripe = stripe_q;
    assign busy      = seq_busy;
    assign req_ready = !seq_busy;

endmodule

// File: rtl/r5_sw_checker.sv
// Module r5_sw_checker
// Port-level protocol properties of the small-write controller; bound
// to every instance of the top module below.
// Assumes: synchronous active-low reset on rst_n.
module r5_sw_checker #(
    parameter int NUM_DISKS = 5,
    parameter int LBA_W     = 16,
    parameter int BLK_W     = 32,
    localparam int DW       = $clog2(NUM_DISKS)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic             busy,
    input logic             done,
    input logic             dk_valid,
    input logic             dk_ready,
    input logic [DW-1:0]    dk_disk,
    input logic [LBA_W-1:0] dk_stripe,
    input logic             dk_write,
    input logic [BLK_W-1:0] dk_wdata
);

    // R6: a stalled command keeps every field
    p_cmd_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        dk_valid && !dk_ready |=> dk_valid && $stable(dk_disk) && $stable(dk_stripe)
                                  && $stable(dk_write) && $stable(dk_wdata));

    // R9: no disk command when idle
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !dk_valid);

    // R9, R5: acceptance starts with a read command
    p_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> busy && dk_valid && !dk_write);

    // R10: done lasts one cycle
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10: done follows a write handshake
    p_done_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(dk_valid && dk_ready && dk_write));

    // R4: disk index in range
    p_disk_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dk_valid |-> ({1'b0, dk_disk} < (DW+1)'(NUM_DISKS)));

    // R2: stripe steady during a sequence
    p_stripe_steady_r2: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) |-> $stable(dk_stripe));

endmodule

bind r5_small_write_ctrl r5_sw_checker #(
    .NUM_DISKS (NUM_DISKS),
    .LBA_W     (LBA_W),
    .BLK_W     (BLK_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .busy      (busy),
    .done      (done),
    .dk_valid  (dk_valid),
    .dk_ready  (dk_ready),
    .dk_disk   (dk_disk),
    .dk_stripe (dk_stripe),
    .dk_write  (dk_write),
    .dk_wdata  (dk_wdata)
);

// File: tb/r5_small_write_ctrl_tb_top.sv
// Bench for r5_small_write_ctrl: a behavioural disk array with random
// stalls and read latency, and a step-counting reference model compared
// against the ports on every clock.
module r5_small_write_ctrl_tb_top;

    localparam int ND = 5;
    localparam int LW = 16;
    localparam int BW = 32;
    localparam int DW = $clog2(ND);

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          rst_n;
    logic          req_valid;
    logic          req_ready;
    logic [LW-1:0] req_lba;
    logic [BW-1:0] req_data;
    logic          busy;
    logic          done;
    logic          dk_valid;
    logic          dk_ready;
    logic [DW-1:0] dk_disk;
    logic [LW-1:0] dk_stripe;
    logic          dk_write;
    logic [BW-1:0] dk_wdata;
    logic          rd_valid;
    logic [BW-1:0] rd_data;

    r5_small_write_ctrl #(.NUM_DISKS(ND), .LBA_W(LW), .BLK_W(BW)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_lba(req_lba), .req_data(req_data), .busy(busy), .done(done),
        .dk_valid(dk_valid), .dk_ready(dk_ready), .dk_disk(dk_disk),
        .dk_stripe(dk_stripe), .dk_write(dk_write), .dk_wdata(dk_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data)
    );

    int vectors = 0;
    int miscompares = 0;
    int wd = 0;
    bit spur = 0;

    // ---------------- disk image ----------------
    logic [BW-1:0] mem [int];

    function automatic int par_of(int s);
        return (ND - 1) - (s % ND);
    endfunction

    function automatic logic [BW-1:0] hsh(int d, int s);
        return BW'((d + 1) * 32'h9E3779B9 + s * 32'h7F4A7C15 + 32'h1234);
    endfunction

    function automatic logic [BW-1:0] mem_rd(int d, int s);
        logic [BW-1:0] x;
        if (mem.exists(d * 65536 + s)) return mem[d * 65536 + s];
        if (d != par_of(s)) return hsh(d, s);
        x = '0;
        for (int k = 0; k < ND; k++) if (k != par_of(s)) x = x ^ hsh(k, s);
        return x;
    endfunction

    task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    endtask

    // ---------------- disk responder ----------------
    bit            hs_prev = 0;
    int            h_d, h_s;
    bit            h_w;
    logic [BW-1:0] h_wd;
    bit            pend = 0;
    int            lat;
    logic [BW-1:0] pdat;

    always @(negedge clk) begin
        if (!rst_n) begin
            dk_ready = 1'b0; rd_valid = 1'b0; rd_data = '0; hs_prev = 0; pend = 0;
        end else begin
            if (hs_prev) begin
                if (h_w) mem[h_d * 65536 + h_s] = h_wd;
                else begin pend = 1; lat = $urandom % 3; pdat = mem_rd(h_d, h_s); end
            end
            rd_valid = 1'b0;
            rd_data  = BW'($urandom);
            if (pend) begin
                if (lat == 0) begin rd_valid = 1'b1; rd_data = pdat; pend = 0; end
                else lat--;
            end else if (spur && ($urandom % 3 == 0)) begin
                rd_valid = 1'b1;  // R8: stray strobe, no read awaiting
            end
            dk_ready = ($urandom % 4) != 0;
            h_d = int'(dk_disk); h_s = int'(dk_stripe); h_w = dk_write; h_wd = dk_wdata;
            hs_prev = dk_valid && dk_ready;
        end
    end

    // ---------------- reference model, compared every clock ----------------
    bit            m_busy = 0, m_done = 0;
    int            m_phase = 0, m_step = 0;
    int            e_disk [4];
    bit            e_wr [4];
    logic [BW-1:0] e_wdata [4];
    int            e_stripe;

    always begin
        @(negedge clk); #2;
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_phase = 0; m_step = 0;
            chk("R1", "busy in reset", 64'(busy), 64'(0));
            chk("R1", "done in reset", 64'(done), 64'(0));
            chk("R1", "dk_valid in reset", 64'(dk_valid), 64'(0));
            chk("R1", "req_ready in reset", 64'(req_ready), 64'(1));
        end else begin
            chk("R9", "busy", 64'(busy), 64'(m_busy));
            chk("R9", "req_ready", 64'(req_ready), 64'(!m_busy));
            chk("R10", "done", 64'(done), 64'(m_done));
            chk("R6", "dk_valid", 64'(dk_valid), 64'(m_phase == 1));
            if (m_phase == 1 && dk_valid) begin
                chk((m_step % 2) ? "R3" : "R4", "dk_disk", 64'(dk_disk), 64'(e_disk[m_step]));
                chk("R2", "dk_stripe", 64'(dk_stripe), 64'(e_stripe));
                chk("R5", "dk_write", 64'(dk_write), 64'(e_wr[m_step]));
                if (m_step == 2) chk("R5", "data write", 64'(dk_wdata), 64'(e_wdata[2]));
                if (m_step == 3) chk(spur ? "R8" : "R7", "parity write", 64'(dk_wdata), 64'(e_wdata[3]));
            end
            // advance the model over the coming edge
            m_done = 0;
            if (m_phase == 1 && dk_ready) begin
                if (m_step < 2) m_phase = 2;
                else if (m_step == 2) m_step = 3;
                else begin m_busy = 0; m_phase = 0; m_done = 1; end
            end else if (m_phase == 2 && rd_valid) begin
                m_step++; m_phase = 1;
            end else if (!m_busy && req_valid) begin
                int l, s, c, p, d;
                l = int'(req_lba); s = l / 4; c = l % 4; p = 4 - (s % 5);
                d = (c < p) ? c : c + 1;
                e_stripe = s;
                e_disk[0] = d; e_disk[1] = p; e_disk[2] = d; e_disk[3] = p;
                e_wr[0] = 0; e_wr[1] = 0; e_wr[2] = 1; e_wr[3] = 1;
                e_wdata[0] = '0; e_wdata[1] = '0; e_wdata[2] = req_data;
                e_wdata[3] = req_data ^ mem_rd(d, s) ^ mem_rd(p, s);
                m_busy = 1; m_phase = 1; m_step = 0;
            end
        end
    end

    // ---------------- host driver ----------------
    task automatic wr(int lba, logic [BW-1:0] d);
        bit ok;
        @(negedge clk);
        req_valid = 1'b1; req_lba = LW'(lba); req_data = d;
        forever begin
            #1 ok = req_ready;
            @(negedge clk);
            if (ok) break;
        end
        req_valid = 1'b0;
    endtask

    task automatic wait_idle();
        int n = 0;
        do begin @(negedge clk); #1; n = busy ? 0 : n + 1; end while (n < 3);
    endtask

    // ---------------- watchdog ----------------
    always @(posedge clk) begin
        wd++;
        if (wd > 150000) begin
            miscompares++;
            $display("FAIL watchdog actual=%0d expected=<150000", wd);
            summary();
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_lba = '0; req_data = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R2, R3, R4: every column of ten stripes, back to back
        for (int i = 0; i < 40; i++) wr(i, BW'(32'hA5000000 + i * 32'h01010101));
        wait_idle();
        // R9: request while busy is refused
        wr(7, 32'hCAFEF00D);
        repeat (2) @(negedge clk);
        req_valid = 1'b1; req_lba = LW'(13); req_data = 32'hBAD0BAD0;
        @(negedge clk);
        req_valid = 1'b0;
        wait_idle();
        // R8: stray read strobes with random traffic
        spur = 1;
        for (int i = 0; i < 30; i++) wr(int'($urandom % 60), BW'($urandom));
        wait_idle();
        spur = 0;
        // R7: every touched stripe must still XOR to zero
        for (int s = 0; s < 16; s++) begin
            logic [BW-1:0] x = '0;
            for (int d = 0; d < ND; d++) x = x ^ mem_rd(d, s);
            chk("R7", "stripe xor", 64'(x), 64'(0));
        end
        summary();
        $finish;
    end

endmodule